// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of instruction bytes ahead of an execution-side consumer. On its own initiative it reads 16-bit words from an instruction memory port whenever it has room for a whole word, splits each returned word into two bytes (lower-addressed byte first, taken from the least significant half), and hands bytes out one at a time over a valid/ready pair.

When the store is empty, a byte arriving from memory is offered to the consumer in the very cycle it arrives, without waiting to be written first. A flush input models a taken branch: the stored bytes are dropped, any fetch in progress is abandoned, and fetching resumes at the supplied byte address. A target at an odd address is handled by reading the even-aligned word that holds it and keeping only its upper byte; later fetches are word aligned.

The memory port is a request/acknowledge pair: the block raises a request with an even word address and holds both until an acknowledge arrives together with the word. Only one fetch is outstanding at a time.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is held and immediately after it, outValid and memReq are 0; the first request after reset carries address RESET_ADDR (default 0x00FF0).
- R2: A request is raised when no fetch is outstanding and at least 2 of the 6 byte slots are free; memReq and memAddr stay unchanged until memAck is seen (or a flush occurs).
- R3: The queue never holds more than 6 bytes: with the consumer stalled it stops requesting once full, still requests nothing with only 1 slot free, and requests again once 2 slots are free.
- R4: Bytes leave in first-in first-out order; from a fetched word at even address A, byte A (memData[7:0]) leaves before byte A+1 (memData[15:8]).
- R5: With the queue empty, in a cycle where memAck is accepted, outValid is 1 and outData equals the first byte of that word in the same cycle.
- R6: A flush empties the queue; in the cycle after it memReq is 0, and the next byte delivered is the byte at the flush address.
- R7: After a flush to an odd address T, the first request uses address T with bit 0 cleared, only memData[15:8] is kept, and the following request uses T+1.
- R8: A memAck arriving in the same cycle as a flush is ignored; none of its bytes is ever delivered.
- R9: After each accepted full word the fetch address advances by 2, so bytes delivered between flushes come from consecutive addresses.
- R10: outValid is 0 in any cycle where flushValid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flushValid | input | 1 | Branch taken: discard contents and restart |
| flushAddr | input | ADDR_W | Byte address to restart fetching from |
| memReq | output | 1 | Word fetch request, held until acknowledged |
| memAddr | output | ADDR_W | Even word address of the fetch |
| memAck | input | 1 | Memory returns the requested word this cycle |
| memData | input | 16 | Returned word, lower address in bits 7:0 |
| outValid | output | 1 | A byte is offered to the consumer |
| outData | output | 8 | Offered instruction byte |
| outReady | input | 1 | Consumer takes the offered byte |

## Verification
Every cycle, assertions watch the occupancy bound, the rule that a request is only up while two slots are free, the holding of request and address until acknowledge, the empty and quiet state after a flush, same-cycle bypass on an empty queue, and the absence of a valid byte during a flush. Byte ordering, the address stepping, odd-target realignment and the loss of a word acknowledged during a flush concern values carried across many cycles, so only the bench scenarios that compare the delivered stream with the memory contents can show them.

// File: rtl/prefetch_pkg.sv
package prefetch_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic clear;      // drop all stored bytes
    logic pushOne;    // store exactly one byte from the returned word
    logic pushTwo;    // store both bytes of the returned word
    logic highFirst;  // the single byte kept is the upper half
    logic bypass;     // queue empty: offer incoming byte directly
    logic pop;        // consumer takes the head byte
  } qStrobe_t;
endpackage

// File: rtl/prefetch_datapath.sv
module prefetch_datapath
  import prefetch_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  qStrobe_t    strobe,
  input  logic [15:0] memData,
  output logic [7:0]  outData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrNext;
  logic [7:0]       firstByte;
  logic             wrFirst;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p, input logic [1:0] n);
    logic [PTR_W:0] sum;
    sum = {1'b0, p} + {{(PTR_W-1){1'b0}}, n};
    if (sum >= (PTR_W+1)'(DEPTH)) sum = sum - (PTR_W+1)'(DEPTH);
    return sum[PTR_W-1:0];
  endfunction

  assign firstByte = strobe.highFirst ? memData[15:8] : memData[7:0];
  assign wrFirst   = strobe.pushOne | strobe.pushTwo;
  assign wrPtrNext = bump(wrPtr, 2'd1);
  assign outData   = strobe.bypass ? firstByte : slots[rdPtr];

  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (wrFirst && wrPtr == PTR_W'(s))
        slots[s] <= firstByte;
      else if (strobe.pushTwo && wrPtrNext == PTR_W'(s))
        slots[s] <= memData[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      wrPtr <= bump(wrPtr, {strobe.pushTwo, strobe.pushOne});
      rdPtr <= bump(rdPtr, {1'b0, strobe.pop});
    end
  end

  // One push width per cycle (R4 ordering relies on it)
  assert_single_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.pushOne, strobe.pushTwo}));
endmodule

// File: rtl/prefetch_ctrl.sv
module prefetch_ctrl
  import prefetch_pkg::*;
#(
  parameter int          DEPTH      = 6,
  parameter int          ADDR_W     = 20,
  parameter int unsigned RESET_ADDR = 32'h0000_0FF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              memAck,
  input  logic              outReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              outValid,
  output qStrobe_t          strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ROOM_CNT  = CNT_W'(DEPTH - 2);

  logic [CNT_W-1:0]  count;
  logic              busy;
  logic [ADDR_W-1:0] fetchAddr;
  logic              ackAccept, startFetch, oddHead, popTake, isEmpty;
  logic [CNT_W-1:0]  pushN;

  assign oddHead    = fetchAddr[0];
  assign isEmpty    = (count == '0);
  assign ackAccept  = busy && memAck && !flushValid;
  assign startFetch = !busy && !flushValid && (count <= ROOM_CNT);
  assign outValid   = !flushValid && (!isEmpty || ackAccept);
  assign popTake    = outValid && outReady;
  assign pushN      = !ackAccept ? '0 : (oddHead ? CNT_W'(1) : CNT_W'(2));

  assign memReq  = busy;
  assign memAddr = {fetchAddr[ADDR_W-1:1], 1'b0};

  always_comb begin
    strobe.clear     = flushValid;
    strobe.pushOne   = ackAccept && oddHead;
    strobe.pushTwo   = ackAccept && !oddHead;
    strobe.highFirst = oddHead;
    strobe.bypass    = isEmpty;
    strobe.pop       = popTake;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      busy      <= 1'b0;
      fetchAddr <= ADDR_W'(RESET_ADDR);
    end else if (flushValid) begin
      count     <= '0;
      busy      <= 1'b0;
      fetchAddr <= flushAddr;
    end else begin
      count <= count + pushN - CNT_W'(popTake);
      if (startFetch)     busy <= 1'b1;
      else if (ackAccept) busy <= 1'b0;
      if (ackAccept)
        fetchAddr <= fetchAddr + (oddHead ? ADDR_W'(1) : ADDR_W'(2));
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  assert_req_has_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> count <= ROOM_CNT);

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck && !flushValid) |=> (memReq && $stable(memAddr)));

  assert_flush_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flushValid |=> (!memReq && count == '0));

  assert_empty_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && memReq && memAck && !flushValid) |-> outValid);

  assert_flush_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flushValid |-> !outValid);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import prefetch_pkg::*;
#(
  parameter int          DEPTH      = 6,
  parameter int          ADDR_W     = 20,
  parameter int unsigned RESET_ADDR = 32'h0000_0FF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [15:0]       memData,
  output logic              outValid,
  output logic [7:0]        outData,
  input  logic              outReady
);
  qStrobe_t strobe;

  prefetch_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flushValid(flushValid), .flushAddr(flushAddr),
    .memAck(memAck), .outReady(outReady), .memReq(memReq), .memAddr(memAddr),
    .outValid(outValid), .strobe(strobe)
  );

  prefetch_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .memData(memData), .outData(outData)
  );
endmodule

// File: tb/prefetch_queue_tb.sv
`timescale 1ns/100ps
module prefetch_queue_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flushValid = 1'b0;
  logic [19:0] flushAddr = '0;
  logic        memReq;
  logic [19:0] memAddr;
  logic        memAck = 1'b0;
  logic [15:0] memData = '0;
  logic        outValid;
  logic [7:0]  outData;
  logic        outReady = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit memOn = 1'b0;
  int memLat = 0;
  int waitCnt = 0;
  logic [7:0] rx [256];
  int rxCount = 0;

  always #2 clk = ~clk;

  prefetch_queue u_dut (
    .clk(clk), .rst_n(rst_n), .flushValid(flushValid), .flushAddr(flushAddr),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  function automatic logic [7:0] byteAt(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory responder
  initial forever begin
    @(negedge clk);
    if (memReq && memOn) begin
      if (waitCnt >= memLat) begin
        memAck  = 1'b1;
        memData = {byteAt(memAddr + 20'd1), byteAt(memAddr)};
        waitCnt = 0;
      end else begin
        memAck = 1'b0;
        waitCnt++;
      end
    end else begin
      memAck  = 1'b0;
      waitCnt = 0;
    end
  end

  // consumer monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && outValid && outReady && rxCount < 256) begin
      rx[rxCount] = outData;
      rxCount++;
    end
  end

  // watchdog
  initial forever begin
    @(posedge clk);
    cycles++;
    if (cycles > 100000) begin
      chk(1'b0, "watchdog", cycles, 100000);
      finishRun();
    end
  end

  task automatic doFlush(input logic [19:0] a);
    @(negedge clk);
    flushAddr  = a;
    flushValid = 1'b1;
    rxCount    = 0;
    @(negedge clk);
    flushValid = 1'b0;
  endtask

  task automatic waitRx(input int n);
    for (int i = 0; i < 400 && rxCount < n; i++) @(negedge clk);
  endtask

  task automatic checkStream(input logic [19:0] base, input int n, input string req);
    waitRx(n);
    chk(rxCount >= n, req, rxCount, n);
    for (int i = 0; i < n && i < rxCount; i++)
      chk(rx[i] == byteAt(base + 20'(i)), req, rx[i], byteAt(base + 20'(i)));
  endtask

  task automatic waitReq();
    for (int i = 0; i < 50 && !memReq; i++) begin @(negedge clk); #1; end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    #1;
    chk(outValid == 1'b0, "R1 outValid in reset", outValid, 0);
    chk(memReq == 1'b0, "R1 memReq in reset", memReq, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    chk(memReq == 1'b0, "R1 memReq after reset", memReq, 0);
    waitReq();
    chk(memAddr == 20'h00FF0, "R1 first address", memAddr, 20'h00FF0);
    // R2: request held with stable address while memory is silent
    repeat (3) @(negedge clk);
    #1;
    chk(memReq == 1'b1 && memAddr == 20'h00FF0, "R2 request held", memAddr, 20'h00FF0);
  endtask

  task automatic testStream();
    memLat = 1;
    outReady = 1'b1;
    memOn = 1'b1;
    checkStream(20'h00FF0, 20, "R4 R9 stream from reset");
  endtask

  task automatic testBackpressure();
    memLat = 0;
    outReady = 1'b0;
    doFlush(20'h00200);
    repeat (40) @(negedge clk);
    #1;
    chk(memReq == 1'b0, "R3 no request when full", memReq, 0);
    chk(outValid && outData == byteAt(20'h00200), "R3 head while full", outData, byteAt(20'h00200));
    @(negedge clk); outReady = 1'b1;
    @(negedge clk); outReady = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    chk(memReq == 1'b0, "R3 no request with one free slot", memReq, 0);
    @(negedge clk); outReady = 1'b1;
    @(negedge clk); outReady = 1'b0;
    waitReq();
    chk(memReq == 1'b1, "R3 request with two free slots", memReq, 1);
    chk(memAddr == 20'h00206, "R9 next word address", memAddr, 20'h00206);
    outReady = 1'b1;
    checkStream(20'h00200, 12, "R4 order after stall");
  endtask

  task automatic testBypass();
    memLat = 3;
    outReady = 1'b1;
    doFlush(20'h00300);
    for (int i = 0; i < 50; i++) begin
      #1;
      if (memAck) break;
      @(negedge clk);
    end
    chk(memAck == 1'b1, "R5 ack seen", memAck, 1);
    chk(outValid == 1'b1, "R5 bypass valid", outValid, 1);
    chk(outData == byteAt(20'h00300), "R5 bypass data", outData, byteAt(20'h00300));
    checkStream(20'h00300, 8, "R6 stream after flush");
  endtask

  task automatic testOdd();
    memLat = 1;
    outReady = 1'b1;
    doFlush(20'h00133);
    #1;
    chk(memReq == 1'b0, "R6 no request after flush", memReq, 0);
    waitReq();
    chk(memAddr == 20'h00132, "R7 aligned first address", memAddr, 20'h00132);
    for (int i = 0; i < 50 && memReq; i++) begin @(negedge clk); #1; end
    waitReq();
    chk(memAddr == 20'h00134, "R7 following address", memAddr, 20'h00134);
    checkStream(20'h00133, 9, "R7 odd target stream");
  endtask

  task automatic testFlushOnAck();
    memLat = 2;
    outReady = 1'b1;
    doFlush(20'h00500);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      #1;
      if (memAck) break;
    end
    flushAddr  = 20'h00400;
    flushValid = 1'b1;
    #0.5;
    chk(outValid == 1'b0, "R10 no valid during flush", outValid, 0);
    rxCount = 0;
    @(negedge clk);
    flushValid = 1'b0;
    #1;
    chk(memReq == 1'b0, "R6 quiet after flush", memReq, 0);
    checkStream(20'h00400, 10, "R8 stale word dropped");
  endtask

  initial begin
    testReset();
    testStream();
    testBackpressure();
    testBypass();
    testOdd();
    testFlushOnAck();
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule